// File: doc/BRIEF.md
# Quadrature Output Formatter and Serializer

This block sits after the sine/cosine lookup of a digital oscillator. It takes a pair of two's-complement amplitude samples and the phase word that produced them, and drives two output buses, one for sine and one for cosine. Each bus can run in one of two ways. In parallel mode the whole word is presented and refreshed on every clock. In serial mode each word is sent out on two pins at once: bit 15 of the bus carries the word MSB first, and bit 0 carries it LSB first. A word strobe tells a downstream converter when a new word starts.

A coding input picks plain two's complement or offset binary for the samples. A test input, honoured only in parallel mode, replaces the samples with the phase word so that the phase path can be observed on the same pins. Each bus has its own active-low output enable, which is modelled as an enable flag beside the bus. Every mode and control input is captured in an input register one clock before it acts. As a result, a sample or mode change presented before clock edge k shows on the outputs after edge k+1.

Top module: `quad_out_fmt`

## Requirements
- R1: With `twos_fmt` low, the MSB of each sample word is inverted, giving offset binary. For example, 8001h becomes 0001h and 7FFFh becomes FFFFh. With `twos_fmt` high, the words pass unchanged.
- R2: With `par_mode` high, both buses show the full formatted word, and they are updated on every clock. An input applied before edge k appears after edge k+1.
- R3: With `par_mode` low, a word is captured into the shift registers in the cycle in which the registered `load_n` is low. It then shifts by one bit per clock while `load_n` stays high, so one load cycle and fifteen shift cycles carry a full 16-bit word.
- R4: In serial mode, bus bit 15 carries the MSB-first stream and bus bit 0 carries the LSB-first stream. Bits 14 down to 1 are driven to zero.
- R5: In serial mode with no new load, the MSB-first stream emits zeros after the LSB. The LSB-first stream repeats the top bit of the loaded word after its MSB.
- R6: `dac_strobe_n` is low for exactly the cycle in which the first bit of a newly loaded word is on the serial pins. It stays high in parallel mode, even when `load_n` is low.
- R7: With `test_mode` and `par_mode` both high, phase bits 27:12 appear on the sine bus. Phase bits 11:0 appear on cosine bits 15:4, and cosine bits 3:0 are zero. No format inversion is applied to these phase bits.
- R8: `test_mode` has no effect in serial mode: the samples are serialized as usual.
- R9: `sin_en` is high exactly when `sin_oe_n` is low, and `cos_en` is high exactly when `cos_oe_n` is low.
- R10: Every mode input (`par_mode`, `test_mode`, `twos_fmt`, `load_n`) acts one clock after it is sampled. A mode change therefore reaches the outputs on the same two-edge schedule as data.
- R11: During reset, both buses are zero and `dac_strobe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sin_smp | input | 16 | Sine sample, two's complement |
| cos_smp | input | 16 | Cosine sample, two's complement |
| phase | input | 28 | Phase word behind the samples |
| load_n | input | 1 | Serial word load, active low |
| par_mode | input | 1 | 1 = parallel, 0 = serial |
| test_mode | input | 1 | 1 = show phase instead of samples (parallel only) |
| twos_fmt | input | 1 | 1 = two's complement, 0 = offset binary |
| sin_oe_n | input | 1 | Sine bus output enable, active low |
| cos_oe_n | input | 1 | Cosine bus output enable, active low |
| sin_bus | output | 16 | Sine output bus |
| cos_bus | output | 16 | Cosine output bus |
| sin_en | output | 1 | Sine bus driven flag |
| cos_en | output | 1 | Cosine bus driven flag |
| dac_strobe_n | output | 1 | First-bit word strobe, active low |

## Verification
The parallel path is driven with the extreme codes 8001h and 7FFFh, zero, and mixed-bit values, first in both codings and then in test mode. These patterns separate a missing or misplaced MSB inversion from an error in the phase bit slicing. The serial path is exercised with a negative sine word and a positive cosine word, so that zero fill and sign repetition give different bit streams. It is run for more than sixteen cycles past a load, which shows what both streams emit after the last data bit. Serial loads with the test input set, and parallel cycles with the load input low, show whether the test and strobe gates depend on the registered mode.

// File: rtl/qof_pkg.sv
package qof_pkg;
   typedef struct packed {
      logic par;
      logic test;
      logic twos;
      logic load_n;
   } qof_mode_t;

   localparam qof_mode_t QOF_MODE_RST = '{par: 1'b1, test: 1'b0, twos: 1'b1, load_n: 1'b1};
endpackage

// File: rtl/qof_word_sel.sv
module qof_word_sel
   import qof_pkg::*;
#(
   parameter int W      = 16,
   parameter int PW     = 28,
   parameter bit IS_SIN = 1'b1
) (
   input  logic [W-1:0]  sample,
   input  logic [PW-1:0] phase,
   input  qof_mode_t     mode,
   output logic [W-1:0]  word
);
   localparam int REST = PW - W;

   logic [W-1:0] fmt_w;
   logic [W-1:0] ph_w;

   always_comb begin
      fmt_w = sample;
      if (!mode.twos) fmt_w[W-1] = ~sample[W-1];
   end

   generate
      if (IS_SIN) begin : g_hi
         assign ph_w = phase[PW-1 -: W];
      end else if (REST == W) begin : g_full
         assign ph_w = phase[REST-1:0];
      end else begin : g_pad
         assign ph_w = {phase[REST-1:0], {(W-REST){1'b0}}};
      end
   endgenerate

   assign word = (mode.par && mode.test) ? ph_w : fmt_w;
endmodule

// File: rtl/qof_lane.sv
module qof_lane #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ser,
   input  logic         ld,
   input  logic [W-1:0] word,
   output logic [W-1:0] bus
);
   logic [W-1:0] msb_sr;
   logic [W-1:0] lsb_sr;
   logic         o_ser;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msb_sr <= '0;
         lsb_sr <= '0;
         o_ser  <= 1'b0;
      end else begin
         o_ser <= ser;
         if (!ser || ld) begin
            msb_sr <= word;
            lsb_sr <= word;
         end else begin
            msb_sr <= {msb_sr[W-2:0], 1'b0};
            lsb_sr <= {lsb_sr[W-1], lsb_sr[W-1:1]};
         end
      end
   end

   always_comb begin
      if (o_ser) bus = {msb_sr[W-1], {(W-2){1'b0}}, lsb_sr[0]};
      else       bus = msb_sr;
   end

   // R2
   par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser |=> (bus == $past(word)));

   // R5
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser && !ld) |=> (bus[W-1] == $past(msb_sr[W-2])));

   // R5
   sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser && !ld) |=> (lsb_sr[W-1] == $past(lsb_sr[W-1])));

   // R4
   idle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser |=> (bus[W-2:1] == '0));
endmodule

// File: rtl/quad_out_fmt.sv
module quad_out_fmt
   import qof_pkg::*;
#(
   parameter int W  = 16,
   parameter int PW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  sin_smp,
   input  logic [W-1:0]  cos_smp,
   input  logic [PW-1:0] phase,
   input  logic          load_n,
   input  logic          par_mode,
   input  logic          test_mode,
   input  logic          twos_fmt,
   input  logic          sin_oe_n,
   input  logic          cos_oe_n,
   output logic [W-1:0]  sin_bus,
   output logic [W-1:0]  cos_bus,
   output logic          sin_en,
   output logic          cos_en,
   output logic          dac_strobe_n
);
   generate
      if (W < 4) begin : g_bad_w
         $error("quad_out_fmt: W must be at least 4");
      end
      if (PW <= W || PW > 2*W) begin : g_bad_pw
         $error("quad_out_fmt: PW must lie in (W, 2W]");
      end
   endgenerate

   qof_mode_t    s_mode;
   logic [W-1:0] s_sin, s_cos;
   logic [PW-1:0] s_phase;
   logic [W-1:0] sin_word, cos_word;
   logic         ser, ld;

   // R10: every mode and data input is captured one clock ahead of use
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_mode  <= QOF_MODE_RST;
         s_sin   <= '0;
         s_cos   <= '0;
         s_phase <= '0;
      end else begin
         s_mode  <= '{par: par_mode, test: test_mode, twos: twos_fmt, load_n: load_n};
         s_sin   <= sin_smp;
         s_cos   <= cos_smp;
         s_phase <= phase;
      end
   end

   assign ser = !s_mode.par;
   assign ld  = !s_mode.load_n;

   qof_word_sel #(.W(W), .PW(PW), .IS_SIN(1'b1)) u_sel_sin (
      .sample(s_sin), .phase(s_phase), .mode(s_mode), .word(sin_word));
   qof_word_sel #(.W(W), .PW(PW), .IS_SIN(1'b0)) u_sel_cos (
      .sample(s_cos), .phase(s_phase), .mode(s_mode), .word(cos_word));

   qof_lane #(.W(W)) u_lane_sin (
      .clk(clk), .rst_n(rst_n), .ser(ser), .ld(ld), .word(sin_word), .bus(sin_bus));
   qof_lane #(.W(W)) u_lane_cos (
      .clk(clk), .rst_n(rst_n), .ser(ser), .ld(ld), .word(cos_word), .bus(cos_bus));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_strobe_n <= 1'b1;
      else        dac_strobe_n <= !(ser && ld);
   end

   assign sin_en = !sin_oe_n;
   assign cos_en = !cos_oe_n;

   // R6
   strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_strobe_n |-> $past(ser));

   // R6
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser && !ld) |=> dac_strobe_n);
endmodule

// File: tb/quad_out_fmt_test.sv
module quad_out_fmt_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sin_smp = '0, cos_smp = '0;
   logic [27:0] phase = '0;
   logic        load_n = 1'b1, par_mode = 1'b1, test_mode = 1'b0, twos_fmt = 1'b1;
   logic        sin_oe_n = 1'b1, cos_oe_n = 1'b1;
   logic [15:0] sin_bus, cos_bus;
   logic        sin_en, cos_en, dac_strobe_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      int          at;
      logic [15:0] s;
      logic [15:0] c;
      logic        stb;
      string       tag;
   } exp_t;
   exp_t q[$];

   logic [15:0] ms = '0, ls = '0, mc = '0, lc = '0;

   quad_out_fmt uut (
      .clk(clk), .rst_n(rst_n), .sin_smp(sin_smp), .cos_smp(cos_smp), .phase(phase),
      .load_n(load_n), .par_mode(par_mode), .test_mode(test_mode), .twos_fmt(twos_fmt),
      .sin_oe_n(sin_oe_n), .cos_oe_n(cos_oe_n), .sin_bus(sin_bus), .cos_bus(cos_bus),
      .sin_en(sin_en), .cos_en(cos_en), .dac_strobe_n(dac_strobe_n));

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, expv);
      end
   endtask

   // Monitor: compare each expected item in the cycle it is due (R10 latency)
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at == cyc) begin
         check({q[0].tag, " sin"}, {16'h0, sin_bus}, {16'h0, q[0].s});
         check({q[0].tag, " cos"}, {16'h0, cos_bus}, {16'h0, q[0].c});
         check({q[0].tag, " strobe"}, {31'h0, dac_strobe_n}, {31'h0, q[0].stb});
         void'(q.pop_front());
      end
   end

   // Driver: apply one cycle of stimulus and push the outputs it must produce
   task automatic step(logic [15:0] s, logic [15:0] c, logic [27:0] ph,
                       logic ldn, logic par, logic tst, logic tw);
      exp_t e;
      logic [15:0] ws, wc;
      sin_smp = s; cos_smp = c; phase = ph;
      load_n = ldn; par_mode = par; test_mode = tst; twos_fmt = tw;
      ws = tw ? s : {~s[15], s[14:0]};            // R1
      wc = tw ? c : {~c[15], c[14:0]};
      e.at = cyc + 2;
      if (par) begin
         if (tst) begin                            // R7
            ws = ph[27:12];
            wc = {ph[11:0], 4'h0};
            e.tag = "R7";
         end else e.tag = tw ? "R2" : "R1";
         ms = ws; ls = ws; mc = wc; lc = wc;
         e.s = ms; e.c = mc; e.stb = 1'b1;
         if (!ldn) e.tag = "R6";
      end else begin
         if (!ldn) begin                           // R3 load
            ms = ws; ls = ws; mc = wc; lc = wc;
            e.stb = 1'b0; e.tag = tst ? "R8" : "R6";
         end else begin                            // R3 shift, R5 fill
            ms = {ms[14:0], 1'b0}; ls = {ls[15], ls[15:1]};
            mc = {mc[14:0], 1'b0}; lc = {lc[15], lc[15:1]};
            e.stb = 1'b1; e.tag = "R5";
         end
         e.s = {ms[15], 14'h0, ls[0]};            // R4
         e.c = {mc[15], 14'h0, lc[0]};
      end
      q.push_back(e);
      @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 sin", {16'h0, sin_bus}, 32'h0);
      check("R11 cos", {16'h0, cos_bus}, 32'h0);
      check("R11 strobe", {31'h0, dac_strobe_n}, 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 enable flags
      sin_oe_n = 1'b0; #1;
      check("R9 sin_en", {30'h0, sin_en, cos_en}, 32'h2);
      cos_oe_n = 1'b0; sin_oe_n = 1'b1; #1;
      check("R9 cos_en", {30'h0, sin_en, cos_en}, 32'h1);
      @(negedge clk);

      // R2 parallel two's complement
      step(16'h8001, 16'h7FFF, 28'h0, 1, 1, 0, 1);
      step(16'h7FFF, 16'h8001, 28'h0, 1, 1, 0, 1);
      step(16'h0000, 16'h1234, 28'h0, 1, 1, 0, 1);
      step(16'hABCD, 16'h5A5A, 28'h0, 1, 1, 0, 1);
      // R1 offset binary
      step(16'h8001, 16'h7FFF, 28'h0, 1, 1, 0, 0);
      step(16'h0000, 16'hC3C3, 28'h0, 1, 1, 0, 0);
      // R7 phase bypass, format ignored
      step(16'h1111, 16'h2222, 28'hABCDEF1, 1, 1, 1, 0);
      step(16'h1111, 16'h2222, 28'h1234567, 1, 1, 1, 1);
      // R6 load low in parallel: no strobe
      step(16'h4321, 16'h8765, 28'h0, 0, 1, 0, 1);
      step(16'h4321, 16'h8765, 28'h0, 0, 1, 0, 1);

      // R3 R4 R5 R6 serial, negative sine, positive cosine
      step(16'hC3A5, 16'h5A3C, 28'h0, 0, 0, 0, 1);
      for (int i = 0; i < 18; i++) step(16'h0, 16'h0, 28'h0, 1, 0, 0, 1);
      // R1 in serial, R8 test ignored
      step(16'h0123, 16'h8F0F, 28'hFFFFFFF, 0, 0, 1, 0);
      for (int i = 0; i < 15; i++) step(16'h0, 16'h0, 28'hFFFFFFF, 1, 0, 1, 0);
      // back-to-back word
      step(16'h9001, 16'h0FF0, 28'h0, 0, 0, 0, 1);
      for (int i = 0; i < 17; i++) step(16'h0, 16'h0, 28'h0, 1, 0, 0, 1);
      // R10 return to parallel
      step(16'h2468, 16'hFEDC, 28'h0, 1, 1, 0, 1);
      step(16'h1357, 16'h0002, 28'h0, 1, 1, 0, 1);
      repeat (4) @(negedge clk);

      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard left %0d items", q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule